// File: doc/BRIEF.md
# Converter Status Flag Register

This block holds the 24-bit status word of a multi-channel converter controller. The conversion, calibration, sequencer and wait engines, and the per-channel over-range and under-range detectors, each send one-cycle event pulses. The block turns every pulse into a sticky flag. Each flag then stays set until one of its own clear conditions occurs. The host clears flags as a side effect of its register accesses: reading the status address, or writing one of the start addresses. The sequencer can also clear a flag directly with its internal pulses.

The block also keeps one pending bit for each of the eight result registers. A finished conversion marks its destination register as unread. Reading that result register clears the mark. An aggregate data-ready flag stays up for as long as any result register is still unread. The host interface has a read strobe, a write strobe and an address. The status word is always visible on an output, so the host samples it in the same cycle as its read strobe.

Top module: `adc_status_reg`

## Requirements
- R1: Word layout: bit 16+n is the over-range flag of channel n, and bit 8+n is the under-range flag of channel n (n = 0..7). Bit 7 is the gain over-range flag, bit 4 is data-ready, bit 3 is wait-done, bit 2 is calibration-ready, bit 1 is sequence-ready and bit 0 is conversion-ready. Bits 6:5 always read 0. After reset the whole word is 0.
- R2: An event pulse in cycle t sets its flag, and the flag is visible in cycle t+1. The flag then holds until one of its clear conditions occurs.
- R3: The over-range, under-range and gain over-range flags clear only on a status read, which is host_rd with host_addr equal to the status address (0x38). The word shown during the read strobe cycle is the value before the clear. The cleared value appears in the next cycle.
- R4: Wait-done clears on a status read or on a host write to the wait-start address (0x04).
- R5: Calibration-ready clears on a status read or on a host write to the calibration-start address (0x03).
- R6: Sequence-ready clears on any of four events: a status read, a host write to the sequence-start address (0x02), an internal sequence-start pulse, or a sequence wrap pulse.
- R7: Conversion-ready clears on a status read, on a host write to the conversion-start address (0x01), or on the pre-result clear pulse.
- R8: A conversion-done pulse sets conversion-ready and marks result register conv_dest as pending. Data-ready is 1 in the next cycle. A status read does not change data-ready.
- R9: A host read of address 0x30+n clears the pending mark of result register n. Data-ready drops in the cycle after the read of the last pending register.
- R10: When a set and a clear of the same flag or pending mark occur in the same cycle, the set wins and the bit reads 1.
- R11: Host accesses that match none of the listed clear rules change no bit. This covers a write to the status address, and a read of a result register that is not pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 6 | Host register address |
| stat_word | output | 24 | Current status word |
| ovr_evt | input | 8 | Per-channel over-range pulses |
| unr_evt | input | 8 | Per-channel under-range pulses |
| gain_ovr_evt | input | 1 | Gain over-range pulse |
| wait_done_evt | input | 1 | Wait operation finished |
| cal_done_evt | input | 1 | New calibration result stored |
| seq_iter_evt | input | 1 | One sequence iteration finished |
| seq_wrap_evt | input | 1 | Sequence wrapped from last step to step 0 |
| seq_int_start | input | 1 | Sequence-start write issued from inside a sequence |
| conv_done_evt | input | 1 | Conversion result stored |
| conv_dest | input | 3 | Result register index of that conversion |
| conv_pre_clr | input | 1 | Continuous/duty-cycle pre-result clear pulse |

## Verification
Every flag and pending bit sits one register away from its inputs. The effect of a stimulus applied in one cycle is therefore due exactly one clock later. That includes the drop of data-ready after the last pending read. The bench drives inputs just after a falling edge and compares the whole word at the next falling edge, against a model stepped once per cycle. For the read-clear ordering, it also inspects the word during the strobe cycle itself, before the clearing edge, to confirm that the pre-clear value is what the host sees.

// File: rtl/adc_stat_pkg.sv
package adc_stat_pkg;

    localparam int STAT_NCH   = 8;
    localparam int STAT_IDX_W = $clog2(STAT_NCH);
    localparam int STAT_W     = 2 * STAT_NCH + 8;
    localparam int MISC_N     = 5;

    // indices into the single-bit flag vector
    localparam int M_CONV = 0;
    localparam int M_SEQ  = 1;
    localparam int M_CAL  = 2;
    localparam int M_WAIT = 3;
    localparam int M_GAIN = 4;

    typedef struct packed {
        logic [STAT_NCH-1:0] ovr;
        logic [STAT_NCH-1:0] unr;
        logic                gain;
        logic [1:0]          zero;
        logic                drdy;
        logic                wait_d;
        logic                cal;
        logic                seq;
        logic                conv;
    } stat_word_t;

    typedef struct packed {
        logic                  status_rd;
        logic                  conv_wr;
        logic                  seq_wr;
        logic                  cal_wr;
        logic                  wait_wr;
        logic                  data_rd;
        logic [STAT_IDX_W-1:0] data_idx;
    } host_dec_t;

    function automatic stat_word_t pack_word(
        input logic [STAT_NCH-1:0] ovr,
        input logic [STAT_NCH-1:0] unr,
        input logic [MISC_N-1:0]   misc,
        input logic                drdy
    );
        stat_word_t w;
        w.ovr    = ovr;
        w.unr    = unr;
        w.gain   = misc[M_GAIN];
        w.zero   = 2'b00;
        w.drdy   = drdy;
        w.wait_d = misc[M_WAIT];
        w.cal    = misc[M_CAL];
        w.seq    = misc[M_SEQ];
        w.conv   = misc[M_CONV];
        return w;
    endfunction

endpackage

// File: rtl/stat_sticky.sv
module stat_sticky #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set,
    input  logic [W-1:0] clr,
    output logic [W-1:0] q
);
    // set has priority so that no event is lost to a coincident clear
    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= set | (q & ~clr);
    end
endmodule

// File: rtl/stat_host_decode.sv
module stat_host_decode
    import adc_stat_pkg::*;
#(
    parameter int             ADDR_W   = 6,
    parameter logic [ADDR_W-1:0] A_STATUS = 6'h38,
    parameter logic [ADDR_W-1:0] A_CONV   = 6'h01,
    parameter logic [ADDR_W-1:0] A_SEQ    = 6'h02,
    parameter logic [ADDR_W-1:0] A_CAL    = 6'h03,
    parameter logic [ADDR_W-1:0] A_WAIT   = 6'h04,
    parameter logic [ADDR_W-1:0] A_DATA0  = 6'h30
) (
    input  logic              host_rd,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    output host_dec_t         dec
);
    logic [ADDR_W-1:0] data_off;

    always_comb begin
        data_off      = host_addr - A_DATA0;
        dec.status_rd = host_rd && (host_addr == A_STATUS);
        dec.conv_wr   = host_wr && (host_addr == A_CONV);
        dec.seq_wr    = host_wr && (host_addr == A_SEQ);
        dec.cal_wr    = host_wr && (host_addr == A_CAL);
        dec.wait_wr   = host_wr && (host_addr == A_WAIT);
        dec.data_rd   = host_rd && (data_off < ADDR_W'(STAT_NCH));
        dec.data_idx  = data_off[STAT_IDX_W-1:0];
    end
endmodule

// File: rtl/stat_pend_track.sv
module stat_pend_track #(
    parameter int N  = 8,
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fill_vld,
    input  logic [IW-1:0] fill_idx,
    input  logic          drain_vld,
    input  logic [IW-1:0] drain_idx,
    output logic          any_pend
);
    logic [N-1:0] set_v, clr_v, pend;

    for (genvar i = 0; i < N; i++) begin : g_slot
        assign set_v[i] = fill_vld  && (fill_idx  == IW'(i));
        assign clr_v[i] = drain_vld && (drain_idx == IW'(i));
    end

    stat_sticky #(.W(N)) u_pend (
        .clk (clk),
        .rst (rst),
        .set (set_v),
        .clr (clr_v),
        .q   (pend)
    );

    assign any_pend = |pend;
endmodule

// File: rtl/adc_status_reg.sv
module adc_status_reg
    import adc_stat_pkg::*;
#(
    parameter int             ADDR_W   = 6,
    parameter logic [ADDR_W-1:0] A_STATUS = 6'h38,
    parameter logic [ADDR_W-1:0] A_CONV   = 6'h01,
    parameter logic [ADDR_W-1:0] A_SEQ    = 6'h02,
    parameter logic [ADDR_W-1:0] A_CAL    = 6'h03,
    parameter logic [ADDR_W-1:0] A_WAIT   = 6'h04,
    parameter logic [ADDR_W-1:0] A_DATA0  = 6'h30
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  host_rd,
    input  logic                  host_wr,
    input  logic [ADDR_W-1:0]     host_addr,
    output logic [STAT_W-1:0]     stat_word,
    input  logic [STAT_NCH-1:0]   ovr_evt,
    input  logic [STAT_NCH-1:0]   unr_evt,
    input  logic                  gain_ovr_evt,
    input  logic                  wait_done_evt,
    input  logic                  cal_done_evt,
    input  logic                  seq_iter_evt,
    input  logic                  seq_wrap_evt,
    input  logic                  seq_int_start,
    input  logic                  conv_done_evt,
    input  logic [STAT_IDX_W-1:0] conv_dest,
    input  logic                  conv_pre_clr
);
    host_dec_t               dec;
    logic [2*STAT_NCH-1:0]   rng_q;
    logic [MISC_N-1:0]       m_set, m_clr, m_q;
    logic                    drdy;
    stat_word_t              word;

    stat_host_decode #(
        .ADDR_W(ADDR_W), .A_STATUS(A_STATUS), .A_CONV(A_CONV),
        .A_SEQ(A_SEQ), .A_CAL(A_CAL), .A_WAIT(A_WAIT), .A_DATA0(A_DATA0)
    ) u_dec (
        .host_rd   (host_rd),
        .host_wr   (host_wr),
        .host_addr (host_addr),
        .dec       (dec)
    );

    // per-channel range flags: only a status read clears them
    stat_sticky #(.W(2*STAT_NCH)) u_rng (
        .clk (clk),
        .rst (rst),
        .set ({ovr_evt, unr_evt}),
        .clr ({(2*STAT_NCH){dec.status_rd}}),
        .q   (rng_q)
    );

    always_comb begin
        m_set         = '0;
        m_clr         = '0;
        m_set[M_GAIN] = gain_ovr_evt;
        m_clr[M_GAIN] = dec.status_rd;
        m_set[M_WAIT] = wait_done_evt;
        m_clr[M_WAIT] = dec.status_rd | dec.wait_wr;
        m_set[M_CAL]  = cal_done_evt;
        m_clr[M_CAL]  = dec.status_rd | dec.cal_wr;
        m_set[M_SEQ]  = seq_iter_evt;
        m_clr[M_SEQ]  = dec.status_rd | dec.seq_wr | seq_int_start | seq_wrap_evt;
        m_set[M_CONV] = conv_done_evt;
        m_clr[M_CONV] = dec.status_rd | dec.conv_wr | conv_pre_clr;
    end

    stat_sticky #(.W(MISC_N)) u_misc (
        .clk (clk),
        .rst (rst),
        .set (m_set),
        .clr (m_clr),
        .q   (m_q)
    );

    stat_pend_track #(.N(STAT_NCH), .IW(STAT_IDX_W)) u_pend (
        .clk       (clk),
        .rst       (rst),
        .fill_vld  (conv_done_evt),
        .fill_idx  (conv_dest),
        .drain_vld (dec.data_rd),
        .drain_idx (dec.data_idx),
        .any_pend  (drdy)
    );

    always_comb begin
        word = pack_word(rng_q[2*STAT_NCH-1:STAT_NCH], rng_q[STAT_NCH-1:0], m_q, drdy);
    end

    assign stat_word = word;
endmodule

// File: rtl/stat_reg_chk.sv
module stat_reg_chk #(
    parameter int             ADDR_W   = 6,
    parameter logic [ADDR_W-1:0] A_STATUS = 6'h38,
    parameter logic [ADDR_W-1:0] A_WAIT   = 6'h04,
    parameter logic [ADDR_W-1:0] A_DATA0  = 6'h30
) (
    input logic              clk,
    input logic              rst,
    input logic              host_rd,
    input logic              host_wr,
    input logic [ADDR_W-1:0] host_addr,
    input logic [23:0]       stat_word,
    input logic [7:0]        ovr_evt,
    input logic [7:0]        unr_evt,
    input logic              wait_done_evt,
    input logic              seq_iter_evt,
    input logic              seq_wrap_evt,
    input logic              conv_done_evt
);
    logic              st_rd, wait_wr, data_rd;
    logic [ADDR_W-1:0] off;

    assign st_rd   = host_rd && (host_addr == A_STATUS);
    assign wait_wr = host_wr && (host_addr == A_WAIT);
    assign off     = host_addr - A_DATA0;
    assign data_rd = host_rd && (off < ADDR_W'(8));

    AST_RANGE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !st_rd |=> ((stat_word[23:8] & $past(stat_word[23:8])) == $past(stat_word[23:8]))); // R3
    AST_RANGE_RDCLR: assert property (@(posedge clk) disable iff (rst)
        (st_rd && ovr_evt == 8'h00 && unr_evt == 8'h00) |=> (stat_word[23:8] == 16'h0000)); // R3
    AST_WAIT_WRCLR: assert property (@(posedge clk) disable iff (rst)
        (wait_wr && !wait_done_evt) |=> !stat_word[3]); // R4
    AST_SEQ_WRAP: assert property (@(posedge clk) disable iff (rst)
        (seq_wrap_evt && !seq_iter_evt) |=> !stat_word[1]); // R6
    AST_CONV_SET: assert property (@(posedge clk) disable iff (rst)
        conv_done_evt |=> (stat_word[0] && stat_word[4])); // R8
    AST_DRDY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (stat_word[4] && !data_rd) |=> stat_word[4]); // R9
    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        wait_done_evt |=> stat_word[3]); // R10
endmodule

bind adc_status_reg stat_reg_chk #(
    .ADDR_W(ADDR_W), .A_STATUS(A_STATUS), .A_WAIT(A_WAIT), .A_DATA0(A_DATA0)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .host_rd       (host_rd),
    .host_wr       (host_wr),
    .host_addr     (host_addr),
    .stat_word     (stat_word),
    .ovr_evt       (ovr_evt),
    .unr_evt       (unr_evt),
    .wait_done_evt (wait_done_evt),
    .seq_iter_evt  (seq_iter_evt),
    .seq_wrap_evt  (seq_wrap_evt),
    .conv_done_evt (conv_done_evt)
);

// File: tb/sim_adc_status_reg.sv
`timescale 1ns/1ps
module sim_adc_status_reg;

    localparam logic [5:0] A_STATUS = 6'h38;
    localparam logic [5:0] A_CONV   = 6'h01;
    localparam logic [5:0] A_SEQ    = 6'h02;
    localparam logic [5:0] A_CAL    = 6'h03;
    localparam logic [5:0] A_WAIT   = 6'h04;
    localparam logic [5:0] A_DATA0  = 6'h30;

    logic        clk = 1'b0;
    logic        rst;
    logic        host_rd, host_wr;
    logic [5:0]  host_addr;
    logic [23:0] stat_word;
    logic [7:0]  ovr_evt, unr_evt;
    logic        gain_ovr_evt, wait_done_evt, cal_done_evt;
    logic        seq_iter_evt, seq_wrap_evt, seq_int_start;
    logic        conv_done_evt, conv_pre_clr;
    logic [2:0]  conv_dest;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [23:0] exp_w  = '0;
    logic [7:0]  exp_pd = '0;

    always #2 clk = ~clk;

    adc_status_reg #(
        .ADDR_W(6), .A_STATUS(A_STATUS), .A_CONV(A_CONV), .A_SEQ(A_SEQ),
        .A_CAL(A_CAL), .A_WAIT(A_WAIT), .A_DATA0(A_DATA0)
    ) u0 (
        .clk(clk), .rst(rst), .host_rd(host_rd), .host_wr(host_wr),
        .host_addr(host_addr), .stat_word(stat_word),
        .ovr_evt(ovr_evt), .unr_evt(unr_evt), .gain_ovr_evt(gain_ovr_evt),
        .wait_done_evt(wait_done_evt), .cal_done_evt(cal_done_evt),
        .seq_iter_evt(seq_iter_evt), .seq_wrap_evt(seq_wrap_evt),
        .seq_int_start(seq_int_start), .conv_done_evt(conv_done_evt),
        .conv_dest(conv_dest), .conv_pre_clr(conv_pre_clr)
    );

    function automatic string req_of(input int b);
        if (b >= 8)      return "R3";
        if (b == 7)      return "R3";
        if (b == 4)      return "R9";
        if (b == 3)      return "R4";
        if (b == 2)      return "R5";
        if (b == 1)      return "R6";
        if (b == 0)      return "R7";
        return "R1";
    endfunction

    task automatic idle();
        host_rd = 0; host_wr = 0; host_addr = 6'h3f;
        ovr_evt = 0; unr_evt = 0; gain_ovr_evt = 0; wait_done_evt = 0;
        cal_done_evt = 0; seq_iter_evt = 0; seq_wrap_evt = 0; seq_int_start = 0;
        conv_done_evt = 0; conv_dest = 0; conv_pre_clr = 0;
    endtask

    task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // advance one clock with the current inputs, then compare the word to the model
    task automatic cycle();
        logic        st_rd, d_rd;
        logic [5:0]  off;
        logic [7:0]  pd;
        logic [23:0] w;
        off   = host_addr - A_DATA0;
        st_rd = host_rd && host_addr == A_STATUS;
        d_rd  = host_rd && off < 6'd8;
        w     = exp_w;
        w[23:16] = ovr_evt | (w[23:16] & ~{8{st_rd}});
        w[15:8]  = unr_evt | (w[15:8]  & ~{8{st_rd}});
        w[7] = gain_ovr_evt  | (w[7] & ~st_rd);
        w[3] = wait_done_evt | (w[3] & ~(st_rd | (host_wr && host_addr == A_WAIT)));
        w[2] = cal_done_evt  | (w[2] & ~(st_rd | (host_wr && host_addr == A_CAL)));
        w[1] = seq_iter_evt  | (w[1] & ~(st_rd | (host_wr && host_addr == A_SEQ)
                                         | seq_int_start | seq_wrap_evt));
        w[0] = conv_done_evt | (w[0] & ~(st_rd | (host_wr && host_addr == A_CONV)
                                         | conv_pre_clr));
        pd = exp_pd;
        for (int i = 0; i < 8; i++) begin
            pd[i] = (conv_done_evt && conv_dest == 3'(i))
                  | (pd[i] & ~(d_rd && off[2:0] == 3'(i)));
        end
        w[6:5] = 2'b00;
        w[4]   = |pd;
        @(negedge clk);
        exp_w  = w;
        exp_pd = pd;
        checks++;
        if (stat_word !== exp_w) begin
            errors++;
            for (int b = 0; b < 24; b++) begin
                if (stat_word[b] !== exp_w[b]) begin
                    $display("FAIL %s bit %0d actual=%h expected=%h",
                             req_of(b), b, stat_word, exp_w);
                    break;
                end
            end
        end
        idle();
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        idle();
        rst = 1;
        repeat (4) @(negedge clk);
        rst = 0;
        chk("R1 reset word", stat_word, 24'h0);

        // R2: single pulse sets and holds
        cal_done_evt = 1; cycle();
        chk("R2 cal set", 24'(stat_word[2]), 24'h1);
        repeat (3) cycle();
        chk("R2 cal hold", 24'(stat_word[2]), 24'h1);

        // R1: gain bit position and zero bits
        gain_ovr_evt = 1; cycle();
        chk("R1 gain bit7", 24'(stat_word[7]), 24'h1);
        chk("R1 bits6:5 zero", 24'(stat_word[6:5]), 24'h0);

        // R3: host sees pre-clear value during its read strobe
        ovr_evt = 8'h20; unr_evt = 8'h01; cycle();
        host_rd = 1; host_addr = A_STATUS;
        chk("R3 pre-clear ovr5", 24'(stat_word[21]), 24'h1);
        chk("R3 pre-clear unr0", 24'(stat_word[8]), 24'h1);
        cycle();
        chk("R3 cleared", 24'(stat_word[23:7]), 24'h0);

        // R8/R9/R11: pending bookkeeping over two result registers
        conv_done_evt = 1; conv_dest = 3'd2; cycle();
        conv_done_evt = 1; conv_dest = 3'd5; cycle();
        chk("R8 drdy set", 24'(stat_word[4]), 24'h1);
        host_rd = 1; host_addr = A_STATUS; cycle();
        chk("R8 drdy survives status read", 24'(stat_word[4]), 24'h1);
        chk("R7 conv cleared by status read", 24'(stat_word[0]), 24'h0);
        host_rd = 1; host_addr = A_DATA0 + 6'd2; cycle();
        chk("R9 drdy after first of two", 24'(stat_word[4]), 24'h1);
        host_rd = 1; host_addr = A_DATA0 + 6'd7; cycle();
        chk("R11 non-pending read", 24'(stat_word[4]), 24'h1);
        host_rd = 1; host_addr = A_DATA0 + 6'd5; cycle();
        chk("R9 drdy after last", 24'(stat_word[4]), 24'h0);

        // R10: set wins
        wait_done_evt = 1; host_wr = 1; host_addr = A_WAIT; cycle();
        chk("R10 wait set vs clr", 24'(stat_word[3]), 24'h1);
        conv_done_evt = 1; conv_dest = 3'd3; host_rd = 1; host_addr = A_DATA0 + 6'd3; cycle();
        chk("R10 pending set vs read", 24'(stat_word[4]), 24'h1);
        host_wr = 1; host_addr = A_STATUS; cycle();
        chk("R11 write to status", 24'(stat_word[3]), 24'h1);
        host_wr = 1; host_addr = A_WAIT; cycle();
        chk("R4 wait write clear", 24'(stat_word[3]), 24'h0);
        cal_done_evt = 1; cycle();
        host_wr = 1; host_addr = A_CAL; cycle();
        chk("R5 cal write clear", 24'(stat_word[2]), 24'h0);

        // R6: internal start and wrap
        seq_iter_evt = 1; cycle();
        seq_int_start = 1; cycle();
        chk("R6 internal start clear", 24'(stat_word[1]), 24'h0);
        seq_iter_evt = 1; cycle();
        seq_wrap_evt = 1; cycle();
        chk("R6 wrap clear", 24'(stat_word[1]), 24'h0);

        // R7: pre-result clear
        conv_done_evt = 1; conv_dest = 3'd0; cycle();
        conv_pre_clr = 1; cycle();
        chk("R7 pre-result clear", 24'(stat_word[0]), 24'h0);

        // random mix, compared each cycle against the model
        for (int n = 0; n < 4000; n++) begin
            ovr_evt       = 8'($urandom) & 8'($urandom) & 8'($urandom);
            unr_evt       = 8'($urandom) & 8'($urandom) & 8'($urandom);
            gain_ovr_evt  = ($urandom % 8) == 0;
            wait_done_evt = ($urandom % 6) == 0;
            cal_done_evt  = ($urandom % 6) == 0;
            seq_iter_evt  = ($urandom % 6) == 0;
            seq_wrap_evt  = ($urandom % 8) == 0;
            seq_int_start = ($urandom % 10) == 0;
            conv_done_evt = ($urandom % 4) == 0;
            conv_dest     = 3'($urandom);
            conv_pre_clr  = ($urandom % 10) == 0;
            host_rd       = ($urandom % 3) == 0;
            host_wr       = ($urandom % 5) == 0;
            case ($urandom % 8)
                0: host_addr = A_STATUS;
                1: host_addr = A_CONV;
                2: host_addr = A_SEQ;
                3: host_addr = A_CAL;
                4: host_addr = A_WAIT;
                5, 6: host_addr = A_DATA0 + 6'($urandom % 8);
                default: host_addr = 6'($urandom);
            endcase
            cycle();
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule